// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block drives the four status lamps of a 10/100 Ethernet transceiver: activity, link, speed-100 and full-duplex. It takes status flags from the rest of the PHY as inputs: carrier sense, the two per-speed link-good flags, the resolved speed and duplex, an auto-negotiation-busy flag and the line-isolate control bit. From these it forms four active-high "lamp on" terms, and each output flip-flop registers one of them.

Carrier activity is hard to see when it is brief. The activity lamp therefore stays lit for a fixed time after carrier sense goes away, 128 ms by default. A down-counter measures this time, and its length comes from the clock frequency parameter. Each lamp also has its own output polarity. That polarity is taken from one PHY address strap bit, captured while the synchronous reset is held. This lets a board wire each lamp to sink current or to source it, with no extra configuration pins.

Top module: `phy_led_driver`

## Requirements
- R1: While `rst` is sampled high, every LED output goes on the next clock edge to its inactive level, which equals the strap bit that sets its polarity. All four outputs are registered.
- R2: Polarity comes from `phy_addr_i` bit 0 for activity, bit 1 for link, bit 2 for speed-100 and bit 3 for full-duplex. A strap value of 1 makes the lamp active-low (on = 0), and 0 makes it active-high (on = 1). The value is captured on the last clock edge of reset. Strap changes after reset have no effect on any output.
- R3: When `crs_i` is sampled high on an edge, the activity output is at its active level after that edge.
- R4: After the first edge at which `crs_i` is sampled low, the activity output stays active for exactly STRETCH = CLK_HZ/1000*STRETCH_MS further edges, counting that first edge. It is inactive after the edge that follows.
- R5: If `crs_i` rises again during a stretch, the full stretch window starts over from the new fall of carrier.
- R6: The link output is active when `link100_ok_i` is high while `speed100_i` is high, or when `link10_ok_i` is high while `speed100_i` is low. The other speed's flag is ignored.
- R7: The speed-100 output is active when `speed100_i` or `autoneg_busy_i` is high, unless `isolate_i` is high, which always forces it inactive.
- R8: The full-duplex output is active exactly while `full_duplex_i` is high.
- R9: Each output takes its value one edge after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap bits are captured while high |
| crs_i | input | 1 | Carrier sense |
| link10_ok_i | input | 1 | 10 Mb/s link valid |
| link100_ok_i | input | 1 | 100 Mb/s link valid |
| speed100_i | input | 1 | Resolved speed is 100 Mb/s |
| full_duplex_i | input | 1 | Link runs full duplex |
| autoneg_busy_i | input | 1 | Auto-negotiation in progress |
| isolate_i | input | 1 | Line-isolate control bit |
| phy_addr_i | input | ADDR_W | PHY address straps; bits 3:0 set LED polarity |
| led_act_o | output | 1 | Activity LED |
| led_link_o | output | 1 | Link LED |
| led_spd_o | output | 1 | Speed-100 LED |
| led_dup_o | output | 1 | Full-duplex LED |

## Verification
The assertions treat every status input as synchronous to `clk`, so a value sampled at one edge decides the output after that edge. They also treat the straps as settled during the final reset cycle, because the checks made in reset compare each output with the strap value from the cycle before. The bench changes inputs only on falling clock edges. It holds the straps steady through each reset and changes them only afterwards, to show they are ignored.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  localparam int NUM_LEDS = 4;

  typedef enum int {
    LED_ACT  = 0,
    LED_LINK = 1,
    LED_SPD  = 2,
    LED_DUP  = 3
  } led_idx_e;

  function automatic longint unsigned stretch_cycles(longint unsigned clk_hz,
                                                    longint unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

endpackage

// File: rtl/led_pol_latch.sv
module led_pol_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strap_i,
  output logic [N-1:0] pol_o
);
  // Sampled on every reset edge; the last one before release is kept.
  always_ff @(posedge clk) begin
    if (rst) pol_o <= strap_i;
  end
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter longint unsigned CYCLES = 128,
  parameter int              CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES);

  logic busy;
  assign busy = (count_o != '0);

  always_ff @(posedge clk) begin
    if (rst)         count_o <= '0;
    else if (trig_i) count_o <= RELOAD;
    else if (busy)   count_o <= count_o - 1'b1;
  end

  assign active_o = trig_i | busy;
endmodule

// File: rtl/led_out_stage.sv
module led_out_stage #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strap_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] on_i,
  output logic [N-1:0] led_o
);
  for (genvar g = 0; g < N; g++) begin : g_led
    always_ff @(posedge clk) begin
      if (rst) led_o[g] <= strap_i[g];
      else     led_o[g] <= on_i[g] ^ pol_i[g];
    end
  end
endmodule

// File: rtl/phy_led_driver.sv
module phy_led_driver
  import phy_led_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 250_000_000,
  parameter longint unsigned STRETCH_MS = 128,
  parameter int              ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              crs_i,
  input  logic              link10_ok_i,
  input  logic              link100_ok_i,
  input  logic              speed100_i,
  input  logic              full_duplex_i,
  input  logic              autoneg_busy_i,
  input  logic              isolate_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  output logic              led_act_o,
  output logic              led_link_o,
  output logic              led_spd_o,
  output logic              led_dup_o
);
  localparam longint unsigned STRETCH = stretch_cycles(CLK_HZ, STRETCH_MS);
  localparam int              CNT_W   = $clog2(STRETCH + 1);

  logic [NUM_LEDS-1:0] strap;
  logic [NUM_LEDS-1:0] pol_q;
  logic [NUM_LEDS-1:0] lamp_on;
  logic [NUM_LEDS-1:0] led_q;
  logic [CNT_W-1:0]    stretch_cnt;
  logic                act_on;

  assign strap = phy_addr_i[NUM_LEDS-1:0];

  led_pol_latch #(.N(NUM_LEDS)) u_pol (
    .clk     (clk),
    .rst     (rst),
    .strap_i (strap),
    .pol_o   (pol_q)
  );

  led_stretch #(.CYCLES(STRETCH), .CNT_W(CNT_W)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (crs_i),
    .active_o (act_on),
    .count_o  (stretch_cnt)
  );

  always_comb begin
    lamp_on           = '0;
    lamp_on[LED_ACT]  = act_on;
    lamp_on[LED_LINK] = speed100_i ? link100_ok_i : link10_ok_i;
    lamp_on[LED_SPD]  = (speed100_i | autoneg_busy_i) & ~isolate_i;
    lamp_on[LED_DUP]  = full_duplex_i;
  end

  led_out_stage #(.N(NUM_LEDS)) u_out (
    .clk     (clk),
    .rst     (rst),
    .strap_i (strap),
    .pol_i   (pol_q),
    .on_i    (lamp_on),
    .led_o   (led_q)
  );

  assign led_act_o  = led_q[LED_ACT];
  assign led_link_o = led_q[LED_LINK];
  assign led_spd_o  = led_q[LED_SPD];
  assign led_dup_o  = led_q[LED_DUP];
endmodule

// File: rtl/phy_led_checker.sv
module phy_led_checker #(
  parameter longint unsigned CYCLES = 128,
  parameter int              CNT_W  = 8,
  parameter int              ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              crs_i,
  input logic              link10_ok_i,
  input logic              link100_ok_i,
  input logic              speed100_i,
  input logic              full_duplex_i,
  input logic              autoneg_busy_i,
  input logic              isolate_i,
  input logic [ADDR_W-1:0] phy_addr_i,
  input logic              led_act_o,
  input logic              led_link_o,
  input logic              led_spd_o,
  input logic              led_dup_o,
  input logic [3:0]        pol_q,
  input logic [CNT_W-1:0]  stretch_cnt
);
  logic [3:0] leds;
  assign leds = {led_dup_o, led_spd_o, led_link_o, led_act_o};

  a_r1_reset_inactive: assert property (@(posedge clk)
    rst |=> (leds == $past(phy_addr_i[3:0])));

  a_r2_pol_frozen: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(pol_q));

  a_r3_crs_lights: assert property (@(posedge clk) disable iff (rst)
    crs_i |=> (led_act_o == ~pol_q[0]));

  a_r4_stretch_holds: assert property (@(posedge clk) disable iff (rst)
    (!crs_i && stretch_cnt != '0) |=> (led_act_o == ~pol_q[0]));

  a_r4_stretch_ends: assert property (@(posedge clk) disable iff (rst)
    (!crs_i && stretch_cnt == '0) |=> (led_act_o == pol_q[0]));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    stretch_cnt <= CNT_W'(CYCLES));

  a_r6_link_100: assert property (@(posedge clk) disable iff (rst)
    (speed100_i && link100_ok_i) |=> (led_link_o == ~pol_q[1]));

  a_r6_link_10: assert property (@(posedge clk) disable iff (rst)
    (!speed100_i && !link10_ok_i) |=> (led_link_o == pol_q[1]));

  a_r7_isolate_off: assert property (@(posedge clk) disable iff (rst)
    isolate_i |=> (led_spd_o == pol_q[2]));

  a_r7_autoneg_on: assert property (@(posedge clk) disable iff (rst)
    (autoneg_busy_i && !isolate_i) |=> (led_spd_o == ~pol_q[2]));

  a_r8_duplex: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (led_dup_o == ($past(full_duplex_i) ^ pol_q[3])));
endmodule

bind phy_led_driver phy_led_checker #(
  .CYCLES (STRETCH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .crs_i          (crs_i),
  .link10_ok_i    (link10_ok_i),
  .link100_ok_i   (link100_ok_i),
  .speed100_i     (speed100_i),
  .full_duplex_i  (full_duplex_i),
  .autoneg_busy_i (autoneg_busy_i),
  .isolate_i      (isolate_i),
  .phy_addr_i     (phy_addr_i),
  .led_act_o      (led_act_o),
  .led_link_o     (led_link_o),
  .led_spd_o      (led_spd_o),
  .led_dup_o      (led_dup_o),
  .pol_q          (pol_q),
  .stretch_cnt    (stretch_cnt)
);

// File: tb/phy_led_driver_test.sv
`timescale 1ns/1ps
module phy_led_driver_test;
  localparam longint unsigned CLK_HZ = 1000;
  localparam longint unsigned MS     = 128;
  localparam int              N      = int'((CLK_HZ / 1000) * MS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crs = 1'b0, l10 = 1'b0, l100 = 1'b0, spd = 1'b0, fdx = 1'b0, an = 1'b0, iso = 1'b0;
  logic [4:0] addr = 5'b00101;
  logic la, ll, ls, ld;
  logic [3:0] pol;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phy_led_driver #(.CLK_HZ(CLK_HZ), .STRETCH_MS(MS), .ADDR_W(5)) uut (
    .clk(clk), .rst(rst), .crs_i(crs), .link10_ok_i(l10), .link100_ok_i(l100),
    .speed100_i(spd), .full_duplex_i(fdx), .autoneg_busy_i(an), .isolate_i(iso),
    .phy_addr_i(addr), .led_act_o(la), .led_link_o(ll), .led_spd_o(ls), .led_dup_o(ld)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input logic [4:0] a);
    @(negedge clk);
    rst = 1'b1; addr = a; pol = a[3:0];
    crs = 0; l10 = 0; l100 = 0; spd = 0; fdx = 0; an = 0; iso = 0;
    step(); step();
    // R1: inactive level equals strap bit
    check("R1 act reset",  la, pol[0]);
    check("R1 link reset", ll, pol[1]);
    check("R1 spd reset",  ls, pol[2]);
    check("R1 dup reset",  ld, pol[3]);
    rst = 1'b0;
    step();
  endtask

  task automatic t_strap_ignored();
    addr = ~addr;
    fdx = 1'b1;
    step();
    check("R2 dup polarity kept", ld, 1'b1 ^ pol[3]);
    check("R2 act polarity kept", la, pol[0]);
    check("R9 link idle", ll, pol[1]);
    fdx = 1'b0;
    addr = {1'b0, pol};
    step();
    check("R8 dup off", ld, pol[3]);
  endtask

  task automatic t_stretch();
    crs = 1'b1;
    step();
    check("R3 act on with crs", la, ~pol[0]);
    crs = 1'b0;
    repeat (N) @(posedge clk);
    @(negedge clk);
    check("R4 act held at window end", la, ~pol[0]);
    step();
    check("R4 act off after window", la, pol[0]);
  endtask

  task automatic t_retrigger();
    crs = 1'b1; step(); crs = 1'b0;
    repeat (N / 2) @(posedge clk);
    @(negedge clk);
    crs = 1'b1; step(); crs = 1'b0;
    repeat (N) @(posedge clk);
    @(negedge clk);
    check("R5 window restarted", la, ~pol[0]);
    step();
    check("R5 off after restarted window", la, pol[0]);
  endtask

  task automatic t_link();
    spd = 1'b1; l100 = 1'b1; l10 = 1'b0; step();
    check("R6 link100", ll, ~pol[1]);
    l100 = 1'b0; l10 = 1'b1; step();
    check("R6 10 flag ignored at 100", ll, pol[1]);
    spd = 1'b0; step();
    check("R6 link10", ll, ~pol[1]);
    l10 = 1'b0; l100 = 1'b1; step();
    check("R6 100 flag ignored at 10", ll, pol[1]);
    l100 = 1'b0;
  endtask

  task automatic t_speed();
    spd = 1'b1; an = 1'b0; iso = 1'b0; step();
    check("R7 speed100 on", ls, ~pol[2]);
    iso = 1'b1; step();
    check("R7 isolate forces off", ls, pol[2]);
    spd = 1'b0; an = 1'b1; step();
    check("R7 isolate beats autoneg", ls, pol[2]);
    iso = 1'b0; step();
    check("R7 autoneg on", ls, ~pol[2]);
    an = 1'b0; step();
    check("R7 10M off", ls, pol[2]);
  endtask

  task automatic t_duplex();
    fdx = 1'b1; step();
    check("R8 duplex on", ld, ~pol[3]);
    fdx = 1'b0; step();
    check("R8 duplex off", ld, pol[3]);
  endtask

  initial begin
    do_reset(5'b00101);
    t_strap_ignored();
    t_stretch();
    t_retrigger();
    t_link();
    t_speed();
    t_duplex();
    do_reset(5'b11010);
    t_strap_ignored();
    t_stretch();
    t_link();
    t_speed();
    t_duplex();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule